// File: doc/BRIEF.md
# Predicated Contiguous Vector Load Sequencer

This block carries out one contiguous load of 32-bit unsigned words into a vector of `VL` bits. A request gives a 64-bit base address, the index of the register that supplied it, a 4-bit signed immediate, a byte-granular predicate and an element-size code. The block scales the immediate by the vector's footprint in memory, adds it to the base, and then visits the elements one at a time. Each active element costs one 32-bit read on a valid/ready port, and the word is zero-extended into that element's slot. An inactive element costs no read and leaves zeros in its slot.

The assembled vector appears on `vec_out` in one update, together with a single-cycle `done`. When the base came from the stack pointer (index 31) and that pointer is not 16-byte aligned, the request ends with `align_fault` and no reads. A wide-element request that is not allowed under the current mode ends with `illegal_op` and no reads. In both cases `done` still pulses and `vec_out` keeps its old value.

Top module: `vload_seq`

## Requirements
- R1: After reset, `busy`, `done`, `align_fault`, `illegal_op` and `rd_valid` are low and `vec_out` is all zeros.
- R2: `esz_sel` 2'b00, 2'b01 and 2'b10 select 32-, 64- and 128-bit elements, and the element count is VL/esize. The start address is base + sext(imm) × (VL/esize) × 4, computed modulo 2^64.
- R3: Element e is given the address start + 4·e whether it is active or not. Reads go out in increasing element order.
- R4: Element e is active when `pred` bit e·esize/8 is set. Each active element issues exactly one read and each inactive element issues none.
- R5: An active element's word appears zero-extended at bits e·esize upward of `vec_out`.
- R6: Every bit of an inactive element's slot in `vec_out` is zero.
- R7: `vec_out` changes only in the cycle in which `done` is high. `done` lasts exactly one cycle per accepted request.
- R8: With `base_idx` = 31, a base whose low four bits are not zero, and at least one active element, the request ends with `done` and `align_fault` and no read, and `vec_out` is unchanged. A base from any other index never faults.
- R9: With `base_idx` = 31, a misaligned base and no active element, the fault is raised when `CHK_SP_IDLE` = 1 (the default) and not raised when it is 0.
- R10: `esz_sel` = 2'b11, or 128-bit elements while `streaming` is high and `full_feat_en` is low, ends the request with `done` and `illegal_op` and no read, and `vec_out` is unchanged. Illegal takes precedence over the alignment fault.
- R11: A read with `rd_ready` low keeps `rd_valid` high and `rd_addr` stable. The sequencer moves on only after `rsp_valid`.
- R12: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| base_addr | input | 64 | Base address value |
| base_idx | input | 5 | Register index that supplied the base (31 = stack pointer) |
| imm | input | 4 | Signed vector-multiple offset |
| pred | input | VL/8 | Predicate, one bit per vector byte |
| esz_sel | input | 2 | Element size code |
| streaming | input | 1 | Streaming mode active |
| full_feat_en | input | 1 | Full feature set enabled in streaming mode |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 64 | Read byte address |
| rd_ready | input | 1 | Memory accepts the read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| align_fault | output | 1 | Stack-pointer alignment fault, with done |
| illegal_op | output | 1 | Illegal variant, with done |
| vec_out | output | VL | Destination vector |

## Verification
On every cycle the assertions check the read handshake hold and that a read is only ever raised for an element the predicate decoder marks active. They also check that `done` is a single pulse, that `vec_out` moves only with `done` and never on a fault, and that the two error flags never come together. Only the bench's sweeps can show the values themselves: the scaled start address for every immediate and size, address wrap, the per-element read addresses, and the placement and zero-extension of the data. The same holds for the fault and illegal decisions under each combination of base index, alignment, predicate and mode inputs, and for a second start being ignored while busy.

// File: rtl/vload_pkg.sv
package vload_pkg;

    typedef enum logic [1:0] {
        ESZ_W32  = 2'b00,
        ESZ_W64  = 2'b01,
        ESZ_W128 = 2'b10,
        ESZ_RSVD = 2'b11
    } esz_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WALK,
        ST_WAIT,
        ST_COMMIT
    } state_e;

    localparam logic [4:0] SP_INDEX = 5'd31;

    // Captured request
    typedef struct packed {
        logic [63:0] base;
        logic        on_sp;
        logic [3:0]  imm;
        esz_e        esz;
        logic        strm;
        logic        full_en;
    } op_t;

    // log2(esize/32)
    function automatic logic [1:0] esz_shift(esz_e e);
        case (e)
            ESZ_W64:  return 2'd1;
            ESZ_W128: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic logic [63:0] sext_imm(logic [3:0] v);
        return {{60{v[3]}}, v};
    endfunction

    function automatic logic illegal_combo(esz_e e, logic strm, logic fen);
        return (e == ESZ_RSVD) || ((e == ESZ_W128) && strm && !fen);
    endfunction

endpackage

// File: rtl/vload_addr_gen.sv
module vload_addr_gen
    import vload_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic [63:0] base,
    input  logic [3:0]  imm,
    input  esz_e        esz,
    output logic [63:0] start_addr,
    output logic        base_misaligned
);
    localparam int VB_LOG2 = $clog2(VL / 8);

    logic [6:0]  shamt;
    logic [63:0] offset;

    // bytes per vector footprint = VL/8 >> log2(esize/32)
    assign shamt           = 7'(VB_LOG2) - {5'd0, esz_shift(esz)};
    assign offset          = sext_imm(imm) << shamt;
    assign start_addr      = base + offset;
    assign base_misaligned = |base[3:0];

endmodule

// File: rtl/vload_pred_decode.sv
module vload_pred_decode
    import vload_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic [VL/8-1:0]  pred,
    input  esz_e             esz,
    output logic [VL/32-1:0] act,
    output logic             any_act
);
    localparam int NE = VL / 32;

    logic [NE-1:0] act32, act64, act128;

    for (genvar e = 0; e < NE; e++) begin : g_elem
        assign act32[e] = pred[e*4];
        if (e < NE / 2) begin : g_w64
            assign act64[e] = pred[e*8];
        end else begin : g_n64
            assign act64[e] = 1'b0;
        end
        if (e < NE / 4) begin : g_w128
            assign act128[e] = pred[e*16];
        end else begin : g_n128
            assign act128[e] = 1'b0;
        end
    end

    always_comb begin
        case (esz)
            ESZ_W32:  act = act32;
            ESZ_W64:  act = act64;
            ESZ_W128: act = act128;
            default:  act = '0;
        endcase
    end

    assign any_act = |act;

    logic pred_unused;
    assign pred_unused = ^pred;

endmodule

// File: rtl/vload_lane_merge.sv
module vload_lane_merge
    import vload_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [$clog2(VL/32)-1:0]   idx,
    input  esz_e                       esz,
    input  logic [31:0]                wdata,
    output logic [VL-1:0]              acc
);
    localparam int NW = VL / 32;
    localparam int IW = $clog2(NW);

    logic [1:0] sh;
    assign sh = esz_shift(esz);

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [31:0]   word_q;
        logic [IW-1:0] owner;
        logic          lowest;

        assign owner  = IW'(w) >> sh;
        assign lowest = ((IW'(w) & ((IW'(1) << sh) - IW'(1))) == '0);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                word_q <= '0;
            end else if (wr_en && (owner == idx)) begin
                word_q <= lowest ? wdata : 32'd0;
            end
        end

        assign acc[w*32 +: 32] = word_q;
    end

endmodule

// File: rtl/vload_seq.sv
module vload_seq
    import vload_pkg::*;
#(
    parameter int       VL          = 256,
    parameter bit       CHK_SP_IDLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [63:0]      base_addr,
    input  logic [4:0]       base_idx,
    input  logic [3:0]       imm,
    input  logic [VL/8-1:0]  pred,
    input  logic [1:0]       esz_sel,
    input  logic             streaming,
    input  logic             full_feat_en,
    output logic             rd_valid,
    output logic [63:0]      rd_addr,
    input  logic             rd_ready,
    input  logic             rsp_valid,
    input  logic [31:0]      rsp_data,
    output logic             busy,
    output logic             done,
    output logic             align_fault,
    output logic             illegal_op,
    output logic [VL-1:0]    vec_out
);
    localparam int NE = VL / 32;
    localparam int PW = VL / 8;
    localparam int IW = $clog2(NE);
    localparam logic [IW:0] NE_W = (IW+1)'(NE);

    state_e          st_q;
    op_t             op_q;
    logic [PW-1:0]   pred_q;
    logic [IW-1:0]   idx_q;
    logic [63:0]     addr_q;
    logic [VL-1:0]   vec_q;
    logic            done_q, fault_q, ill_q;

    logic [63:0]     start_addr;
    logic            base_mis;
    logic [NE-1:0]   act;
    logic            any_act;
    logic            cur_active;
    logic [IW:0]     n_elem;
    logic            last;
    logic            is_illegal, is_fault;
    logic            wr_en, advance, accept;
    logic [31:0]     wdata;
    logic [VL-1:0]   acc;

    vload_addr_gen #(.VL(VL)) u_addr (
        .base            (op_q.base),
        .imm             (op_q.imm),
        .esz             (op_q.esz),
        .start_addr      (start_addr),
        .base_misaligned (base_mis)
    );

    vload_pred_decode #(.VL(VL)) u_pred (
        .pred    (pred_q),
        .esz     (op_q.esz),
        .act     (act),
        .any_act (any_act)
    );

    assign accept     = (st_q == ST_IDLE) && start;
    assign cur_active = act[idx_q];
    assign n_elem     = NE_W >> esz_shift(op_q.esz);
    assign last       = ({1'b0, idx_q} == (n_elem - 1'b1));
    assign is_illegal = illegal_combo(op_q.esz, op_q.strm, op_q.full_en);
    assign is_fault   = op_q.on_sp && base_mis && (any_act || CHK_SP_IDLE);

    // One element retires either by skipping or by a returned word
    assign wr_en   = ((st_q == ST_WALK) && !cur_active) ||
                     ((st_q == ST_WAIT) && rsp_valid);
    assign advance = wr_en;
    assign wdata   = (st_q == ST_WAIT) ? rsp_data : 32'd0;

    vload_lane_merge #(.VL(VL)) u_merge (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .wr_en (wr_en),
        .idx   (idx_q),
        .esz   (op_q.esz),
        .wdata (wdata),
        .acc   (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            op_q    <= '0;
            pred_q  <= '0;
            idx_q   <= '0;
            addr_q  <= '0;
            vec_q   <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            ill_q   <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q.base    <= base_addr;
                        op_q.on_sp   <= (base_idx == SP_INDEX);
                        op_q.imm     <= imm;
                        op_q.esz     <= esz_e'(esz_sel);
                        op_q.strm    <= streaming;
                        op_q.full_en <= full_feat_en;
                        pred_q       <= pred;
                        st_q         <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (is_illegal) begin
                        ill_q  <= 1'b1;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else if (is_fault) begin
                        fault_q <= 1'b1;
                        done_q  <= 1'b1;
                        st_q    <= ST_IDLE;
                    end else begin
                        addr_q <= start_addr;
                        idx_q  <= '0;
                        st_q   <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (cur_active && rd_ready) begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: ;
                ST_COMMIT: begin
                    vec_q  <= acc;
                    done_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
            if (advance) begin
                addr_q <= addr_q + 64'd4;
                idx_q  <= idx_q + 1'b1;
                st_q   <= last ? ST_COMMIT : ST_WALK;
            end
        end
    end

    assign rd_valid    = (st_q == ST_WALK) && cur_active;
    assign rd_addr     = addr_q;
    assign busy        = (st_q != ST_IDLE);
    assign done        = done_q;
    assign align_fault = fault_q;
    assign illegal_op  = ill_q;
    assign vec_out     = vec_q;

endmodule

// File: rtl/vload_seq_chk.sv
module vload_seq_chk #(
    parameter int VL = 256
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [63:0]   rd_addr,
    input logic          busy,
    input logic          done,
    input logic          align_fault,
    input logic          illegal_op,
    input logic [VL-1:0] vec_out,
    input logic          cur_active
);

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R11

    AST_READ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> cur_active); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_VEC_MOVES_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(vec_out) |-> done); // R7

    AST_FAULT_KEEPS_VEC: assert property (@(posedge clk) disable iff (rst)
        (align_fault || illegal_op) |-> done && $stable(vec_out)); // R8

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(align_fault && illegal_op)); // R10

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_valid); // R12

endmodule

bind vload_seq vload_seq_chk #(.VL(VL)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_addr     (rd_addr),
    .busy        (busy),
    .done        (done),
    .align_fault (align_fault),
    .illegal_op  (illegal_op),
    .vec_out     (vec_out),
    .cur_active  (cur_active)
);

// File: tb/tb_vload_seq.sv
module tb_vload_seq;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [63:0]   base_addr = '0;
    logic [4:0]    base_idx = '0;
    logic [3:0]    imm = '0;
    logic [31:0]   pred = '0;
    logic [1:0]    esz_sel = '0;
    logic          streaming = 1'b0;
    logic          full_feat_en = 1'b0;
    logic          rd_valid;
    logic [63:0]   rd_addr;
    logic          rd_ready;
    logic          rsp_valid = 1'b0;
    logic [31:0]   rsp_data = '0;
    logic          busy, done, align_fault, illegal_op;
    logic [VL-1:0] vec_out;

    int checks = 0;
    int failures = 0;

    always #4ns clk = ~clk;

    vload_seq #(.VL(VL)) dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .base_idx(base_idx), .imm(imm), .pred(pred), .esz_sel(esz_sel),
        .streaming(streaming), .full_feat_en(full_feat_en),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
        .done(done), .align_fault(align_fault), .illegal_op(illegal_op),
        .vec_out(vec_out)
    );

    function automatic logic [31:0] memw(logic [63:0] a);
        return a[31:0] ^ a[63:32] ^ 32'hC0DE_5A17 ^ {a[7:0], a[15:8], a[23:16], a[31:24]};
    endfunction

    // Memory model: ready stalls one cycle in four, data one cycle after accept
    logic [7:0]  cyc = '0;
    int          nlog = 0;
    int          stall_cnt = 0;
    logic [63:0] log_addr [0:4095];

    assign rd_ready = (cyc[1:0] != 2'b11);

    always @(posedge clk) begin
        cyc       <= cyc + 8'd1;
        rsp_valid <= 1'b0;
        if (rd_valid && !rd_ready) stall_cnt <= stall_cnt + 1;
        if (rd_valid && rd_ready) begin
            rsp_valid               <= 1'b1;
            rsp_data                <= memw(rd_addr);
            log_addr[nlog % 4096]   <= rd_addr;
            nlog                    <= nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int shv(logic [1:0] es);
        return (es == 2'd2) ? 2 : (es == 2'd1) ? 1 : 0;
    endfunction

    function automatic logic [63:0] start_of(logic [63:0] b, logic [3:0] im, logic [1:0] es);
        int ne = 8 >> shv(es);
        return b + ({{60{im[3]}}, im} * 64'(ne * 4));
    endfunction

    function automatic logic elem_act(logic [31:0] pr, logic [1:0] es, int e);
        return pr[e * (4 << shv(es))];
    endfunction

    function automatic logic [255:0] exp_vec(logic [63:0] b, logic [3:0] im,
                                             logic [31:0] pr, logic [1:0] es);
        logic [255:0] v = '0;
        int sh = shv(es);
        logic [63:0] sa = start_of(b, im, es);
        for (int e = 0; e < (8 >> sh); e++)
            if (elem_act(pr, es, e)) v[(e << sh) * 32 +: 32] = memw(sa + 64'(4 * e));
        return v;
    endfunction

    task automatic wait_done(output bit got);
        got = 1'b0;
        for (int t = 0; t < 400; t++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_op(input logic [63:0] b, input logic [4:0] bi, input logic [3:0] im,
                          input logic [31:0] pr, input logic [1:0] es,
                          input logic sm, input logic fe);
        logic [255:0] prev, ev, imask;
        logic [63:0]  sa, ea;
        logic         ill, flt, anyact;
        int           n0, k, sh;
        bit           got;
        prev = vec_out;
        n0 = nlog;
        @(negedge clk);
        base_addr = b; base_idx = bi; imm = im; pred = pr; esz_sel = es;
        streaming = sm; full_feat_en = fe; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(got);
        chk(got, "R7", "done seen", 256'(got), 256'(1));
        sh = shv(es);
        sa = start_of(b, im, es);
        anyact = 1'b0;
        for (int e = 0; e < (8 >> sh); e++) anyact |= elem_act(pr, es, e);
        ill = (es == 2'd3) || (es == 2'd2 && sm && !fe);
        flt = !ill && (bi == 5'd31) && (b[3:0] != 4'd0);
        chk(illegal_op == ill, "R10", "illegal flag", 256'(illegal_op), 256'(ill));
        if (anyact)
            chk(align_fault == flt, "R8", "fault flag", 256'(align_fault), 256'(flt));
        else
            chk(align_fault == flt, "R9", "idle fault flag", 256'(align_fault), 256'(flt));
        if (ill || flt) begin
            chk(vec_out == prev, ill ? "R10" : "R8", "vec kept", vec_out, prev);
            chk(nlog == n0, ill ? "R10" : "R8", "no reads", 256'(nlog - n0), 256'(0));
        end else begin
            ev = exp_vec(b, im, pr, es);
            imask = '0;
            k = 0;
            for (int e = 0; e < (8 >> sh); e++) begin
                ea = sa + 64'(4 * e);
                if (elem_act(pr, es, e)) begin
                    chk(log_addr[(n0 + k) % 4096] == ea, (k == 0) ? "R2" : "R3",
                        "read address", 256'(log_addr[(n0 + k) % 4096]), 256'(ea));
                    k++;
                end else begin
                    for (int j = 0; j < (1 << sh); j++)
                        imask[((e << sh) + j) * 32 +: 32] = '1;
                end
            end
            chk(nlog - n0 == k, "R4", "read count", 256'(nlog - n0), 256'(k));
            chk(vec_out == ev, "R5", "vector data", vec_out, ev);
            chk((vec_out & imask) == '0, "R6", "inactive zero", vec_out & imask, '0);
        end
        @(negedge clk);
        chk(!done && !busy, "R7", "done single pulse", 256'({done, busy}), 256'(0));
    endtask

    initial begin
        #1200us;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0]  pats [4];
        logic [31:0]  lc;
        logic [255:0] ev;
        bit           got;
        int           dcount;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !rd_valid, "R1", "reset controls",
            256'({busy, done, rd_valid}), 256'(0));
        chk(!align_fault && !illegal_op, "R1", "reset flags",
            256'({align_fault, illegal_op}), 256'(0));
        chk(vec_out == '0, "R1", "reset vector", vec_out, '0);

        // Sweep sizes, immediates and predicate patterns (R2..R7)
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h0000_0000;
        pats[2] = 32'hA5C3_0F11;
        lc = 32'h1234_5678;
        for (int es = 0; es < 3; es++)
            for (int im = 0; im < 16; im++)
                for (int p = 0; p < 4; p++) begin
                    lc = lc * 32'd1103515245 + 32'd12345;
                    pats[3] = lc;
                    run_op(64'h0000_7F00_0000_1000 + 64'(es * 256 + im * 16 + p * 4),
                           5'd3, 4'(im), pats[p], 2'(es), 1'b0, 1'b0);
                end

        // R2 address wrap modulo 2^64
        run_op(64'hFFFF_FFFF_FFFF_FFF0, 5'd7, 4'd7, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0);
        run_op(64'h0000_0000_0000_0010, 5'd7, 4'h8, 32'h0101_0101, 2'd1, 1'b0, 1'b0);

        // R8 stack pointer cases and non-SP misaligned base
        run_op(64'h0000_0000_0040_0000, 5'd31, 4'd1, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0);
        run_op(64'h0000_0000_0040_0004, 5'd31, 4'd1, 32'h0000_0010, 2'd0, 1'b0, 1'b0);
        run_op(64'h0000_0000_0040_0004, 5'd30, 4'd1, 32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0);
        // R9 stack pointer, misaligned, nothing active (CHK_SP_IDLE = 1)
        run_op(64'h0000_0000_0040_0008, 5'd31, 4'd2, 32'h0000_0000, 2'd1, 1'b0, 1'b0);
        run_op(64'h0000_0000_0040_0010, 5'd31, 4'd2, 32'h0000_0000, 2'd1, 1'b0, 1'b0);

        // R10 mode combinations, including precedence over the fault
        run_op(64'h0000_0000_0050_0000, 5'd2, 4'd0, 32'hFFFF_FFFF, 2'd2, 1'b1, 1'b0);
        run_op(64'h0000_0000_0050_0000, 5'd2, 4'd0, 32'hFFFF_FFFF, 2'd2, 1'b1, 1'b1);
        run_op(64'h0000_0000_0050_0000, 5'd2, 4'd3, 32'hFFFF_FFFF, 2'd3, 1'b0, 1'b0);
        run_op(64'h0000_0000_0050_0000, 5'd2, 4'd3, 32'hFFFF_FFFF, 2'd0, 1'b1, 1'b0);
        run_op(64'h0000_0000_0050_0004, 5'd31, 4'd0, 32'hFFFF_FFFF, 2'd3, 1'b0, 1'b0);

        // R11 stalls occurred and all data above stayed correct
        chk(stall_cnt > 0, "R11", "stall cycles seen", 256'(stall_cnt), 256'(1));

        // R12 second start while busy is ignored
        @(negedge clk);
        base_addr = 64'h0000_0000_0060_0000; base_idx = 5'd4; imm = 4'd1;
        pred = 32'hFFFF_FFFF; esz_sel = 2'd0; streaming = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        imm = 4'hD; esz_sel = 2'd1; start = 1'b1;
        chk(busy, "R12", "busy during op", 256'(busy), 256'(1));
        @(negedge clk);
        start = 1'b0;
        wait_done(got);
        ev = exp_vec(64'h0000_0000_0060_0000, 4'd1, 32'hFFFF_FFFF, 2'd0);
        chk(got && vec_out == ev, "R12", "first request result", vec_out, ev);
        dcount = 0;
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            if (done) dcount++;
        end
        chk(dcount == 0 && !busy, "R12", "no second request", 256'(dcount), 256'(0));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule